// File: doc/BRIEF.md
# Column Readout Phase Sequencer

This block drives the control switches of one column-parallel readout channel across one horizontal line period. The channel has a clamping correlated-double-sampling stage followed by an analog core that is used twice in turn. It first acts as a folding integrator that accumulates the input 2^m times and compares it against one midpoint reference. It then acts as a cyclic converter that runs a fixed number of residue cycles and compares against two references at the quarter points.

A pulse on `line_start` begins a line. The clamp capacitor is charged while the pixel floating node is held in reset. The reset level is then converted in fold mode and then in cyclic mode. Next the pixel transfer pulse is applied, and the same two-mode conversion runs on the signal level. Downstream code-reconstruction logic follows the line using the level flag, a strobe at the end of every DAC transfer phase, and a one-clock line-done pulse.

Every phase lasts the same programmable number of clocks. That number is captured when the line starts.

Top module: `readout_phase_seq`

## Requirements
- R1: While reset is held, and whenever no line is in progress, every output is low.
- R2: In the first phase after an accepted `line_start`, `pix_reset` and `clamp_chg` are high and `clamp_pass` is low.
- R3: From the end of the clamp phase until the line-done cycle (inclusive), `clamp_pass` is high and `clamp_chg` is low. The two are never high together.
- R4: Fold mode runs 2^FOLD_LOG2 cycles (4 by default). Each cycle is a sampling phase with `samp_in` and `samp_hold` high, followed by a transfer phase with `dac_xfer` high. `ref_quarter` is low (midpoint comparator) throughout.
- R5: Cyclic mode runs CYC_N cycles (12 by default). Each cycle is a feedback phase with `fb_samp` and `samp_hold` high, followed by a transfer phase with `dac_xfer` high. `ref_quarter` is high (quarter-point comparators) throughout.
- R6: Every phase lasts `ph_len`+1 clocks, using the value sampled with the accepted `line_start`. Changes to `ph_len` during a line have no effect. A line therefore lasts (ph_len+1)·(2+4·(2^FOLD_LOG2+CYC_N)) + 1 clocks.
- R7: The reset level is converted first, with `level_sig` low. Then a transfer phase with `pix_xfer` high runs, and `level_sig` is high from that phase until the line ends. The signal level is then converted by the same fold and cyclic sequence.
- R8: `code_strobe` is high for exactly the last clock of every DAC transfer phase, and at no other time.
- R9: After the last cyclic transfer phase of the signal level, `line_done` is high for one clock. The block is idle on the next clock.
- R10: A `line_start` pulse arriving while a line is in progress is ignored. The output sequence continues unchanged.
- R11: `samp_hold` and `dac_xfer` are never high together. `ref_quarter` changes only on the clock after the last clock of a phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | Starts a line when idle |
| ph_len | input | PW | Phase length minus one, in clocks |
| pix_reset | output | 1 | Pixel floating-node reset |
| pix_xfer | output | 1 | Pixel charge transfer |
| clamp_chg | output | 1 | Clamp charging switches (first pair) |
| clamp_pass | output | 1 | Clamp pass switch (third) |
| samp_in | output | 1 | Input sampling switch, fold mode |
| samp_hold | output | 1 | Amplifier-side sampling switch, both modes |
| fb_samp | output | 1 | Feedback sampling switch, cyclic mode |
| dac_xfer | output | 1 | DAC charge-transfer switch |
| ref_quarter | output | 1 | Comparator reference: 0 midpoint, 1 quarter points |
| level_sig | output | 1 | Marker: 0 reset level, 1 signal level |
| code_strobe | output | 1 | Marker: last clock of a DAC transfer phase |
| line_done | output | 1 | One-clock end-of-line pulse |

## Verification
The properties assume that `ph_len` may change at any time, and that `line_start` may arrive in any cycle, including mid-line. They rely on the block latching the length and ignoring starts while busy, not on the driver behaving well. The stimulus runs full lines at several phase lengths, including the shortest (one clock) and the longest. It changes `ph_len` and pulses `line_start` in the middle of a line, and it waits for idle only between the lines it compares against. Expected switch patterns are rebuilt cycle by cycle from the phase rules, so a wrong cycle count, phase length or reference change shows up as a per-cycle mismatch.

// File: rtl/readout_seq_pkg.sv
package readout_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CLAMP = 3'd1,
    PH_FSMP  = 3'd2,
    PH_FXFR  = 3'd3,
    PH_CSMP  = 3'd4,
    PH_CXFR  = 3'd5,
    PH_TX    = 3'd6,
    PH_DONE  = 3'd7
  } phase_e;

  // number of integrating folds for a given log2 count
  function automatic int fold_cycles(input int log2m);
    return 1 << log2m;
  endfunction

  // clocks from first clamp clock to the done clock, inclusive
  function automatic int line_clocks(input int len, input int log2m, input int ncyc);
    int l;
    l = len + 1;
    return l + 2 * (2 * fold_cycles(log2m) * l + 2 * ncyc * l) + l + 1;
  endfunction

  function automatic logic is_xfer_phase(input phase_e p);
    return (p == PH_FXFR) || (p == PH_CXFR);
  endfunction

  function automatic logic is_cyclic_phase(input phase_e p);
    return (p == PH_CSMP) || (p == PH_CXFR);
  endfunction

endpackage

// File: rtl/readout_phase_timer.sv
module readout_phase_timer #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  input  logic [PW-1:0] len_in,
  output logic          last,
  output logic [PW-1:0] len_q
);

  logic [PW-1:0] cnt;

  assign last = run && (cnt == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      len_q <= '0;
    end else begin
      if (load) len_q <= len_in;
      if (load || !run || last) cnt <= '0;
      else                      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/readout_cycle_counter.sv
module readout_cycle_counter #(
  parameter int FOLD_N = 4,
  parameter int CYC_N  = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic fold_end,
  output logic cyc_end
);

  localparam int MAXC = (FOLD_N > CYC_N) ? FOLD_N : CYC_N;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] FOLD_TOP = CW'(FOLD_N - 1);
  localparam logic [CW-1:0] CYC_TOP  = CW'(CYC_N - 1);

  logic [CW-1:0] idx;

  assign fold_end = (idx == FOLD_TOP);
  assign cyc_end  = (idx == CYC_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (inc) idx <= idx + 1'b1;
  end

endmodule

// File: rtl/readout_phase_ctrl.sv
module readout_phase_ctrl
  import readout_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   ph_last,
  input  logic   fold_end,
  input  logic   cyc_end,
  output phase_e phase,
  output logic   lvl,
  output logic   accept,
  output logic   cyc_clr,
  output logic   cyc_inc
);

  phase_e phase_n;
  logic   lvl_n;

  always_comb begin
    phase_n = phase;
    lvl_n   = lvl;
    accept  = 1'b0;
    cyc_clr = 1'b0;
    cyc_inc = 1'b0;
    case (phase)
      PH_IDLE: if (start) begin
        phase_n = PH_CLAMP;
        accept  = 1'b1;
        lvl_n   = 1'b0;
      end
      PH_CLAMP: if (ph_last) begin
        phase_n = PH_FSMP;
        cyc_clr = 1'b1;
      end
      PH_FSMP: if (ph_last) phase_n = PH_FXFR;
      PH_FXFR: if (ph_last) begin
        if (fold_end) begin
          phase_n = PH_CSMP;
          cyc_clr = 1'b1;
        end else begin
          phase_n = PH_FSMP;
          cyc_inc = 1'b1;
        end
      end
      PH_CSMP: if (ph_last) phase_n = PH_CXFR;
      PH_CXFR: if (ph_last) begin
        if (cyc_end) begin
          cyc_clr = 1'b1;
          if (lvl) begin
            phase_n = PH_DONE;
          end else begin
            phase_n = PH_TX;
            lvl_n   = 1'b1;
          end
        end else begin
          phase_n = PH_CSMP;
          cyc_inc = 1'b1;
        end
      end
      PH_TX: if (ph_last) begin
        phase_n = PH_FSMP;
        cyc_clr = 1'b1;
      end
      PH_DONE: begin
        phase_n = PH_IDLE;
        lvl_n   = 1'b0;
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      lvl   <= 1'b0;
    end else begin
      phase <= phase_n;
      lvl   <= lvl_n;
    end
  end

endmodule

// File: rtl/readout_switch_decode.sv
module readout_switch_decode
  import readout_seq_pkg::*;
(
  input  phase_e phase,
  input  logic   lvl,
  input  logic   ph_last,
  output logic   busy,
  output logic   pix_reset,
  output logic   pix_xfer,
  output logic   clamp_chg,
  output logic   clamp_pass,
  output logic   samp_in,
  output logic   samp_hold,
  output logic   fb_samp,
  output logic   dac_xfer,
  output logic   ref_quarter,
  output logic   level_sig,
  output logic   code_strobe,
  output logic   line_done
);

  always_comb begin
    busy        = (phase != PH_IDLE);
    pix_reset   = (phase == PH_CLAMP);
    clamp_chg   = (phase == PH_CLAMP);
    clamp_pass  = busy && (phase != PH_CLAMP);
    pix_xfer    = (phase == PH_TX);
    samp_in     = (phase == PH_FSMP);
    fb_samp     = (phase == PH_CSMP);
    samp_hold   = (phase == PH_FSMP) || (phase == PH_CSMP);
    dac_xfer    = is_xfer_phase(phase);
    ref_quarter = is_cyclic_phase(phase);
    level_sig   = lvl;
    code_strobe = is_xfer_phase(phase) && ph_last;
    line_done   = (phase == PH_DONE);
  end

endmodule

// File: rtl/readout_phase_seq.sv
module readout_phase_seq
  import readout_seq_pkg::*;
#(
  parameter int PW        = 4,
  parameter int FOLD_LOG2 = 2,
  parameter int CYC_N     = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic [PW-1:0] ph_len,
  output logic          pix_reset,
  output logic          pix_xfer,
  output logic          clamp_chg,
  output logic          clamp_pass,
  output logic          samp_in,
  output logic          samp_hold,
  output logic          fb_samp,
  output logic          dac_xfer,
  output logic          ref_quarter,
  output logic          level_sig,
  output logic          code_strobe,
  output logic          line_done
);

  localparam int FOLD_N = 1 << FOLD_LOG2;

  phase_e        phase_q;
  logic          lvl_q;
  logic          busy;
  logic          ph_last;
  logic          accept;
  logic          cyc_clr;
  logic          cyc_inc;
  logic          fold_end;
  logic          cyc_end;
  logic [PW-1:0] len_q;

  readout_phase_timer #(.PW(PW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .run    (busy),
    .len_in (ph_len),
    .last   (ph_last),
    .len_q  (len_q)
  );

  readout_cycle_counter #(.FOLD_N(FOLD_N), .CYC_N(CYC_N)) u_cycles (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cyc_clr),
    .inc      (cyc_inc),
    .fold_end (fold_end),
    .cyc_end  (cyc_end)
  );

  readout_phase_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (line_start),
    .ph_last  (ph_last),
    .fold_end (fold_end),
    .cyc_end  (cyc_end),
    .phase    (phase_q),
    .lvl      (lvl_q),
    .accept   (accept),
    .cyc_clr  (cyc_clr),
    .cyc_inc  (cyc_inc)
  );

  readout_switch_decode u_dec (
    .phase       (phase_q),
    .lvl         (lvl_q),
    .ph_last     (ph_last),
    .busy        (busy),
    .pix_reset   (pix_reset),
    .pix_xfer    (pix_xfer),
    .clamp_chg   (clamp_chg),
    .clamp_pass  (clamp_pass),
    .samp_in     (samp_in),
    .samp_hold   (samp_hold),
    .fb_samp     (fb_samp),
    .dac_xfer    (dac_xfer),
    .ref_quarter (ref_quarter),
    .level_sig   (level_sig),
    .code_strobe (code_strobe),
    .line_done   (line_done)
  );

endmodule

// File: rtl/readout_phase_seq_chk.sv
module readout_phase_seq_chk
  import readout_seq_pkg::*;
#(
  parameter int PW        = 4,
  parameter int FOLD_LOG2 = 2,
  parameter int CYC_N     = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          ph_last,
  input logic [PW-1:0] len_q,
  input logic          pix_reset,
  input logic          pix_xfer,
  input logic          clamp_chg,
  input logic          clamp_pass,
  input logic          samp_in,
  input logic          samp_hold,
  input logic          fb_samp,
  input logic          dac_xfer,
  input logic          ref_quarter,
  input logic          level_sig,
  input logic          code_strobe,
  input logic          line_done
);

  logic [31:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(pix_reset || pix_xfer || clamp_chg || clamp_pass || samp_in || samp_hold
                || fb_samp || dac_xfer || ref_quarter || level_sig || code_strobe || line_done));

  a_r3_clamp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(clamp_chg && clamp_pass));

  a_r11_samp_dac_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(samp_hold && dac_xfer));

  a_r11_ref_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_quarter) |-> $past(ph_last));

  a_r8_strobe_end: assert property (@(posedge clk) disable iff (!rst_n)
    code_strobe |-> (dac_xfer && ph_last));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> (!line_done && !busy));

  a_r7_tx_before_signal: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level_sig) |-> pix_xfer);

  a_r6_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(len_q));

  a_r6_line_length: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> (int'(busy_cnt) == line_clocks(int'(len_q), FOLD_LOG2, CYC_N) - 1));

  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !line_done) |=> busy);

endmodule

bind readout_phase_seq readout_phase_seq_chk #(
  .PW(PW), .FOLD_LOG2(FOLD_LOG2), .CYC_N(CYC_N)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .ph_last     (ph_last),
  .len_q       (len_q),
  .pix_reset   (pix_reset),
  .pix_xfer    (pix_xfer),
  .clamp_chg   (clamp_chg),
  .clamp_pass  (clamp_pass),
  .samp_in     (samp_in),
  .samp_hold   (samp_hold),
  .fb_samp     (fb_samp),
  .dac_xfer    (dac_xfer),
  .ref_quarter (ref_quarter),
  .level_sig   (level_sig),
  .code_strobe (code_strobe),
  .line_done   (line_done)
);

// File: tb/tb_readout_phase_seq.sv
module tb_readout_phase_seq;

  localparam int PW         = 4;
  localparam int FOLD_LOG2  = 2;
  localparam int CYC_N      = 12;
  localparam int CLK_PERIOD = 10;
  localparam int FOLDS      = 1 << FOLD_LOG2;

  typedef struct packed {
    logic pix_reset, pix_xfer, clamp_chg, clamp_pass, samp_in, samp_hold;
    logic fb_samp, dac_xfer, ref_quarter, level_sig, code_strobe, line_done;
  } vec_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 1'b0;
  logic [PW-1:0] ph_len = '0;
  vec_t got;

  vec_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   vec_bad;
  string ctx = "reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  readout_phase_seq #(.PW(PW), .FOLD_LOG2(FOLD_LOG2), .CYC_N(CYC_N)) dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .ph_len(ph_len),
    .pix_reset(got.pix_reset), .pix_xfer(got.pix_xfer), .clamp_chg(got.clamp_chg),
    .clamp_pass(got.clamp_pass), .samp_in(got.samp_in), .samp_hold(got.samp_hold),
    .fb_samp(got.fb_samp), .dac_xfer(got.dac_xfer), .ref_quarter(got.ref_quarter),
    .level_sig(got.level_sig), .code_strobe(got.code_strobe), .line_done(got.line_done)
  );

  task automatic cmp(input string req, input string nm, input logic g, input logic e);
    if (g !== e) begin
      $display("FAIL %s [%s] %s got %b expected %b at %0t", req, ctx, nm, g, e, $time);
      vec_bad = 1'b1;
    end
  endtask

  task automatic compare(input vec_t g, input vec_t e);
    vec_bad = 1'b0;
    cmp("R2", "pix_reset",   g.pix_reset,   e.pix_reset);
    cmp("R2", "clamp_chg",   g.clamp_chg,   e.clamp_chg);
    cmp("R3", "clamp_pass",  g.clamp_pass,  e.clamp_pass);
    cmp("R7", "pix_xfer",    g.pix_xfer,    e.pix_xfer);
    cmp("R4", "samp_in",     g.samp_in,     e.samp_in);
    cmp("R4", "samp_hold",   g.samp_hold,   e.samp_hold);
    cmp("R5", "fb_samp",     g.fb_samp,     e.fb_samp);
    cmp("R4", "dac_xfer",    g.dac_xfer,    e.dac_xfer);
    cmp("R5", "ref_quarter", g.ref_quarter, e.ref_quarter);
    cmp("R7", "level_sig",   g.level_sig,   e.level_sig);
    cmp("R8", "code_strobe", g.code_strobe, e.code_strobe);
    cmp("R9", "line_done",   g.line_done,   e.line_done);
    n_vec++;
    if (vec_bad) n_bad++;
  endtask

  // monitor: one expected vector per clock, sampled mid-cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) compare(got, exp_q.pop_front());
  end

  task automatic rep(input vec_t v, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(v);
  endtask

  // one transfer phase: last clock carries the strobe (R8)
  task automatic push_xfer(input vec_t base, input int l);
    vec_t v;
    v = base;
    v.dac_xfer = 1'b1;
    rep(v, l - 1);
    v.code_strobe = 1'b1;
    rep(v, 1);
  endtask

  // expected line built from R2..R9, l = ph_len+1 clocks per phase (R6)
  task automatic push_line(input int l);
    vec_t v;
    v = '0; v.pix_reset = 1'b1; v.clamp_chg = 1'b1;           // R2
    rep(v, l);
    for (int lv = 0; lv < 2; lv++) begin
      vec_t b;
      b = '0; b.clamp_pass = 1'b1; b.level_sig = logic'(lv);   // R3, R7
      if (lv == 1) begin
        v = b; v.pix_xfer = 1'b1;                                // R7
        rep(v, l);
      end
      for (int f = 0; f < FOLDS; f++) begin                      // R4
        v = b; v.samp_in = 1'b1; v.samp_hold = 1'b1;
        rep(v, l);
        push_xfer(b, l);
      end
      b.ref_quarter = 1'b1;                                      // R5
      for (int c = 0; c < CYC_N; c++) begin
        v = b; v.fb_samp = 1'b1; v.samp_hold = 1'b1;
        rep(v, l);
        push_xfer(b, l);
      end
    end
    v = '0; v.clamp_pass = 1'b1; v.level_sig = 1'b1; v.line_done = 1'b1;  // R9
    rep(v, 1);
    v = '0;                                                      // R1, R9 idle after
    rep(v, 3);
  endtask

  task automatic run_line(input string name, input int len, input int disturb_at,
                          input int new_len, input bit extra_start);
    ctx = name;
    @(negedge clk);
    ph_len = PW'(len);
    line_start = 1'b1;
    @(posedge clk);
    #1 line_start = 1'b0;
    push_line(len + 1);
    if (disturb_at > 0) begin
      repeat (disturb_at) @(negedge clk);
      ph_len = PW'(new_len);                                     // R6
      if (extra_start) line_start = 1'b1;                        // R10
      @(negedge clk);
      line_start = 1'b0;
    end
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    n_bad++;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    line_start = 1'b1;                                           // R1: held in reset
    @(negedge clk);
    compare(got, vec_t'('0));
    line_start = 1'b0;
    @(negedge clk);
    compare(got, vec_t'('0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    ctx = "idle R1";
    compare(got, vec_t'('0));

    run_line("R6 shortest phase", 0, 0, 0, 1'b0);
    run_line("R4 R5 two-clock phase", 1, 0, 0, 1'b0);
    run_line("R6 len change mid-line", 2, 30, 9, 1'b0);
    run_line("R10 restart mid-line", 3, 100, 0, 1'b1);
    run_line("R10 restart in signal level", 1, 120, 5, 1'b1);
    run_line("R6 longest phase", (1 << PW) - 1, 0, 0, 1'b0);
    run_line("R7 back-to-back", 0, 0, 0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule